// File: doc/BRIEF.md
# Endpoint-zero OUT handshake controller

This block holds the control and status word for the OUT direction of a USB device's endpoint zero. It also decides how the device answers each packet that arrives on that endpoint. Software reaches the word through a simple 32-bit register port. Writes take effect at the next clock edge. Reads are combinational and return zero when the address does not match the endpoint's address.

The packet engine supplies single-cycle event pulses:
- a SETUP token was seen;
- a SETUP data packet arrived;
- an OUT data packet arrived, together with a flag that says whether its integrity check passed;
- a transfer finished.

A global OUT NAK level comes from elsewhere in the device. From these inputs and the register state the block returns one of four handshake codes, registered one cycle after the packet. It also raises one-cycle setup-done and transfer-done interrupt pulses.

Several fields change by themselves. Software sets the enable and stall fields and the core clears them. The NAK flag has separate write-only set and clear strobes, and the core can also set it.

Top module: `ep0_out_hs_ctrl`

## Requirements
- R1: After reset every field is 0 and the word reads 0x0000_0000. Writes to any address other than the endpoint address change nothing.
- R2: Writing 1 to bit 31 sets the enable. Writing 0 there has no effect. The core clears the enable at the same edge that raises the setup-done or transfer-done interrupt.
- R3: Bit 30, bits 27 and 26, bits 19:18 (the control type code 00) and all unused bits always read 0.
- R4: Writing 1 to bit 27 sets the NAK flag and writing 1 to bit 26 clears it. When both are written together the set wins. Bit 17 reads the flag.
- R5: A finished transfer or a received SETUP data packet sets the NAK flag, even when software clears it in the same cycle.
- R6: Writing 1 to bit 21 sets the stall field and writing 0 has no effect. A SETUP token clears the field, and this clear wins over a software set in the same cycle.
- R7: A SETUP data packet is always answered with ACK (code 01), whatever the stall, NAK, enable and integrity state.
- R8: For an OUT packet, a set stall field gives STALL (code 11) even when the NAK flag or the global OUT NAK is also asserted.
- R9: For an OUT packet without stall, the NAK flag, the global OUT NAK or a cleared enable gives NAK (code 10).
- R10: For an enabled OUT packet that passes the NAK and stall tests, a failed integrity flag gives no handshake (code 00) unless snoop (bit 20, read/write) is set. Otherwise the answer is ACK.
- R11: The handshake code and its valid strobe appear exactly one cycle after each packet event. The strobe lasts one cycle.
- R12: The setup-done and transfer-done interrupts pulse for exactly one cycle, one cycle after their event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, 0 when the address does not match |
| setup_tok | input | 1 | Pulse: SETUP token received |
| setup_pkt | input | 1 | Pulse: SETUP data packet received |
| out_pkt | input | 1 | Pulse: OUT data packet received |
| pkt_ok | input | 1 | Integrity check of the OUT packet passed |
| xfer_done | input | 1 | Pulse: transfer finished |
| glb_out_nak | input | 1 | Device-wide OUT NAK level |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| hs_valid | output | 1 | One-cycle strobe qualifying hs_code |
| setup_done_irq | output | 1 | Setup-done interrupt pulse |
| xfer_done_irq | output | 1 | Transfer-done interrupt pulse |

## Verification
The assertions check the following every cycle:
- the SETUP answer is always ACK;
- stall takes priority for OUT packets;
- the strobe follows exactly one cycle after each packet;
- the core clears the enable and stall fields and sets NAK at the event edges;
- a NAK set strobe always lands.

Only the bench scenarios can show the rest, because each needs a specific prior history of writes:
- the full priority ladder under mixed register states;
- the snoop override;
- read-back of the hardwired and write-only bits;
- that writing zero to a set-only field has no effect;
- that writes to other addresses are ignored.

// File: rtl/ep0_out_pkg.sv
package ep0_out_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned B_EN    = 31;
  localparam int unsigned B_NSET  = 27;
  localparam int unsigned B_NCLR  = 26;
  localparam int unsigned B_STALL = 21;
  localparam int unsigned B_SNOOP = 20;
  localparam int unsigned B_NAKRD = 17;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  // Handshake priority for a packet event.
  function automatic hs_e pick_hs(input logic is_setup, input logic en,
                                  input logic nak, input logic gnak,
                                  input logic stall, input logic snoop,
                                  input logic ok);
    if (is_setup)           return HS_ACK;
    if (stall)              return HS_STALL;
    if (nak || gnak)        return HS_NAK;
    if (!en)                return HS_NAK;
    if (!ok && !snoop)      return HS_NONE;
    return HS_ACK;
  endfunction

  // Read view of the status word.
  function automatic logic [WORD_W-1:0] pack_word(input logic en, input logic stall,
                                                  input logic snoop, input logic nak);
    logic [WORD_W-1:0] w;
    w          = '0;
    w[B_EN]    = en;
    w[B_STALL] = stall;
    w[B_SNOOP] = snoop;
    w[B_NAKRD] = nak;
    return w;
  endfunction
endpackage

// File: rtl/ep0_out_csr.sv
module ep0_out_csr
  import ep0_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_en_set,
  input  logic              sw_nak_set,
  input  logic              sw_nak_clr,
  input  logic              sw_stall_set,
  input  logic              sw_snoop_val,
  input  logic              ev_setup_tok,
  input  logic              ev_setup_pkt,
  input  logic              ev_xfer_done,
  output logic              en_o,
  output logic              nak_o,
  output logic              stall_o,
  output logic              snoop_o,
  output logic [WORD_W-1:0] word_o
);
  logic en_q, nak_q, stall_q, snoop_q;
  logic en_d, nak_d, stall_d, snoop_d;
  logic core_en_clr, nak_set_any;

  assign core_en_clr = ev_setup_pkt | ev_xfer_done;
  assign nak_set_any = (sw_wr & sw_nak_set) | ev_setup_pkt | ev_xfer_done;

  always_comb begin
    en_d    = core_en_clr ? 1'b0 : (en_q | (sw_wr & sw_en_set));
    nak_d   = nak_set_any ? 1'b1 : ((sw_wr & sw_nak_clr) ? 1'b0 : nak_q);
    stall_d = ev_setup_tok ? 1'b0 : (stall_q | (sw_wr & sw_stall_set));
    snoop_d = sw_wr ? sw_snoop_val : snoop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      nak_q   <= 1'b0;
      stall_q <= 1'b0;
      snoop_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      nak_q   <= nak_d;
      stall_q <= stall_d;
      snoop_q <= snoop_d;
    end
  end

  assign en_o    = en_q;
  assign nak_o   = nak_q;
  assign stall_o = stall_q;
  assign snoop_o = snoop_q;
  assign word_o  = pack_word(en_q, stall_q, snoop_q, nak_q);
endmodule

// File: rtl/ep0_out_hs_sel.sv
module ep0_out_hs_sel
  import ep0_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_pkt,
  input  logic       out_pkt,
  input  logic       pkt_ok,
  input  logic       glb_nak,
  input  logic       en,
  input  logic       nak,
  input  logic       stall,
  input  logic       snoop,
  output logic [1:0] hs_code,
  output logic       hs_valid
);
  hs_e  hs_d, hs_q;
  logic vld_q;

  assign hs_d = pick_hs(setup_pkt, en, nak, glb_nak, stall, snoop, pkt_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= HS_NONE;
      vld_q <= 1'b0;
    end else begin
      vld_q <= setup_pkt | out_pkt;
      if (setup_pkt | out_pkt) hs_q <= hs_d;
    end
  end

  assign hs_code  = hs_q;
  assign hs_valid = vld_q;
endmodule

// File: rtl/ep0_out_irq.sv
module ep0_out_irq #(
  parameter int unsigned N_IRQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] ev,
  output logic [N_IRQ-1:0] irq
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ev[i];
    end
    assign irq[i] = q;
  end
endmodule

// File: rtl/ep0_out_hs_ctrl.sv
module ep0_out_hs_ctrl
  import ep0_out_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] EP_ADDR = 12'hB00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              setup_tok,
  input  logic              setup_pkt,
  input  logic              out_pkt,
  input  logic              pkt_ok,
  input  logic              xfer_done,
  input  logic              glb_out_nak,
  output logic [1:0]        hs_code,
  output logic              hs_valid,
  output logic              setup_done_irq,
  output logic              xfer_done_irq
);
  localparam int unsigned IRQ_SETUP = 0;
  localparam int unsigned IRQ_XFER  = 1;
  localparam int unsigned N_IRQ     = 2;

  logic              sel, sw_wr;
  logic              en_q, nak_q, stall_q, snoop_q;
  logic [WORD_W-1:0] word;
  logic [N_IRQ-1:0]  irq_ev, irq_out;
  logic              unused_wdata;

  assign sel   = (reg_addr == EP_ADDR);
  assign sw_wr = sel & reg_we;
  assign unused_wdata = ^{reg_wdata[30:28], reg_wdata[25:22], reg_wdata[19:0]};

  ep0_out_csr u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_wr        (sw_wr),
    .sw_en_set    (reg_wdata[B_EN]),
    .sw_nak_set   (reg_wdata[B_NSET]),
    .sw_nak_clr   (reg_wdata[B_NCLR]),
    .sw_stall_set (reg_wdata[B_STALL]),
    .sw_snoop_val (reg_wdata[B_SNOOP]),
    .ev_setup_tok (setup_tok),
    .ev_setup_pkt (setup_pkt),
    .ev_xfer_done (xfer_done),
    .en_o         (en_q),
    .nak_o        (nak_q),
    .stall_o      (stall_q),
    .snoop_o      (snoop_q),
    .word_o       (word)
  );

  ep0_out_hs_sel u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_pkt (setup_pkt),
    .out_pkt   (out_pkt),
    .pkt_ok    (pkt_ok),
    .glb_nak   (glb_out_nak),
    .en        (en_q),
    .nak       (nak_q),
    .stall     (stall_q),
    .snoop     (snoop_q),
    .hs_code   (hs_code),
    .hs_valid  (hs_valid)
  );

  always_comb begin
    irq_ev            = '0;
    irq_ev[IRQ_SETUP] = setup_pkt;
    irq_ev[IRQ_XFER]  = xfer_done;
  end

  ep0_out_irq #(.N_IRQ(N_IRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (irq_ev),
    .irq   (irq_out)
  );

  assign setup_done_irq = irq_out[IRQ_SETUP];
  assign xfer_done_irq  = irq_out[IRQ_XFER];
  assign reg_rdata      = sel ? word : '0;
endmodule

// File: rtl/ep0_out_chk.sv
module ep0_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr,
  input logic [31:0] reg_wdata,
  input logic       setup_tok,
  input logic       setup_pkt,
  input logic       out_pkt,
  input logic       xfer_done,
  input logic       en_q,
  input logic       nak_q,
  input logic       stall_q,
  input logic [1:0] hs_code,
  input logic       hs_valid,
  input logic       setup_done_irq,
  input logic       xfer_done_irq
);
  assert_core_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_pkt || xfer_done) |=> !en_q);
  assert_nak_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && reg_wdata[27]) |=> nak_q);
  assert_core_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_pkt || xfer_done) |=> nak_q);
  assert_stall_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> !stall_q);
  assert_setup_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_pkt |=> (hs_valid && hs_code == 2'b01));
  assert_stall_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pkt && !setup_pkt && stall_q) |=> (hs_code == 2'b11));
  assert_strobe_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_pkt || out_pkt) |=> hs_valid);
  assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(setup_pkt || out_pkt));
  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> xfer_done_irq);
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done_irq |-> $past(setup_pkt));
endmodule

bind ep0_out_hs_ctrl ep0_out_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_wr          (sw_wr),
  .reg_wdata      (reg_wdata),
  .setup_tok      (setup_tok),
  .setup_pkt      (setup_pkt),
  .out_pkt        (out_pkt),
  .xfer_done      (xfer_done),
  .en_q           (en_q),
  .nak_q          (nak_q),
  .stall_q        (stall_q),
  .hs_code        (hs_code),
  .hs_valid       (hs_valid),
  .setup_done_irq (setup_done_irq),
  .xfer_done_irq  (xfer_done_irq)
);

// File: tb/sim_ep0_out_hs_ctrl.sv
module sim_ep0_out_hs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] EPA = 12'hB00;
  // vector: {word[31:0], glb, ok, is_setup, exp[1:0]}
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {32'h8400_0000, 1'b0, 1'b1, 1'b0, 2'b01},  // R10 enabled good -> ACK
    {32'h0400_0000, 1'b0, 1'b1, 1'b0, 2'b10},  // R9 not enabled -> NAK
    {32'h8C00_0000, 1'b0, 1'b1, 1'b0, 2'b10},  // R9 NAK flag (set beats clear, R4)
    {32'h8400_0000, 1'b1, 1'b1, 1'b0, 2'b10},  // R9 global NAK
    {32'h8C20_0000, 1'b1, 1'b1, 1'b0, 2'b11},  // R8 stall over both NAKs
    {32'h0420_0000, 1'b0, 1'b1, 1'b0, 2'b11},  // R8 stall, not enabled
    {32'h8400_0000, 1'b0, 1'b0, 1'b0, 2'b00},  // R10 bad, no snoop -> none
    {32'h8410_0000, 1'b0, 1'b0, 1'b0, 2'b01},  // R10 bad, snoop -> ACK
    {32'h0C20_0000, 1'b1, 1'b0, 1'b1, 2'b01},  // R7 setup always ACK
    {32'h0400_0000, 1'b0, 1'b0, 1'b0, 2'b10},  // R9 disabled beats integrity
    {32'h8410_0000, 1'b0, 1'b1, 1'b0, 2'b01}   // R10 snoop good -> ACK
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] reg_addr = EPA;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic setup_tok = 0, setup_pkt = 0, out_pkt = 0, pkt_ok = 0, xfer_done = 0, glb_out_nak = 0;
  logic [1:0] hs_code;
  logic hs_valid, setup_done_irq, xfer_done_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_out_hs_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R11 reset strobe", {31'b0, hs_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      setup_tok = 1; xfer_done = 1;
      @(negedge clk);
      setup_tok = 0; xfer_done = 0;
      wr(VEC[i][36:5]);
      glb_out_nak = VEC[i][4]; pkt_ok = VEC[i][3];
      setup_pkt = VEC[i][2]; out_pkt = !VEC[i][2];
      @(negedge clk);
      setup_pkt = 0; out_pkt = 0; glb_out_nak = 0; pkt_ok = 0;
      chk($sformatf("R11 vec%0d strobe", i), {31'b0, hs_valid}, 32'h1);
      chk($sformatf("R7-R10 vec%0d code", i), {30'b0, hs_code}, {30'b0, VEC[i][1:0]});
      @(negedge clk);
      chk($sformatf("R11 vec%0d one cycle", i), {31'b0, hs_valid}, 32'h0);
    end

    // clean state
    setup_tok = 1; xfer_done = 1; @(negedge clk); setup_tok = 0; xfer_done = 0;
    wr(32'h0400_0000);
    chk("R1 clean", reg_rdata, 32'h0);

    reg_addr = 12'hB04; wr(32'hFFFF_FFFF); reg_addr = EPA;
    chk("R1 other address ignored", reg_rdata, 32'h0);
    reg_addr = 12'hB04;
    chk("R1 other address reads 0", reg_rdata, 32'h0);
    reg_addr = EPA;

    wr(32'hFFFF_FFFF);
    chk("R3 R4 all-ones write readback", reg_rdata, 32'h8032_0000);
    wr(32'h0000_0000);
    chk("R2 R6 zero write keeps set-only", reg_rdata, 32'h8022_0000);
    wr(32'h0400_0000);
    chk("R4 clear NAK", reg_rdata, 32'h8020_0000);
    setup_tok = 1; reg_we = 1; reg_wdata = 32'h0020_0000;
    @(negedge clk); setup_tok = 0; reg_we = 0; reg_wdata = '0;
    chk("R6 token clears stall over set", reg_rdata, 32'h8000_0000);

    xfer_done = 1; reg_we = 1; reg_wdata = 32'h0400_0000;
    @(negedge clk); xfer_done = 0; reg_we = 0; reg_wdata = '0;
    chk("R2 R5 xfer clears en sets NAK", reg_rdata, 32'h0002_0000);
    chk("R12 xfer irq", {31'b0, xfer_done_irq}, 32'h1);
    @(negedge clk);
    chk("R12 xfer irq one cycle", {31'b0, xfer_done_irq}, 32'h0);

    wr(32'h8400_0000);
    chk("R2 enable set", reg_rdata, 32'h8000_0000);
    setup_pkt = 1; @(negedge clk); setup_pkt = 0;
    chk("R12 setup irq", {31'b0, setup_done_irq}, 32'h1);
    chk("R2 R5 setup clears en sets NAK", reg_rdata, 32'h0002_0000);
    chk("R7 setup ack", {30'b0, hs_code}, 32'h1);
    @(negedge clk);
    chk("R12 setup irq one cycle", {31'b0, setup_done_irq}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule